// File: doc/BRIEF.md
# Transmit Byte Queue with Watermark Status

This block buffers bytes between a register-bus write port and a serial transmitter. A bus write to the data offset adds one byte to the queue. The transmitter takes bytes from the head of the queue through a valid/ready pair. The queue keeps a fill level and reports full and empty flags in a status word. It reports the level in a level word, together with a receive-side level and flags supplied from outside.

Three event outputs go to an interrupt bank:
- A level-sensitive watermark condition. It is high while the fill level is at or above a threshold chosen by a 2-bit code.
- A one-cycle pulse when the queue drains to zero.
- A one-cycle pulse when a push is dropped because the queue is full.

A control write can flush the queue and sets the threshold code.

Top module: `tx_fifo_wm`

## Requirements
- R1: After reset the level is 0, `tx_valid` is low, all three events are low, and `status_word` equals 0x3C when `rx_flags` is 3'b111.
- R2: A bus write to offset 0x18 stores `bus_wdata` as one byte and raises the level by one. Bytes leave on `tx_byte` in the order they were written, and `tx_valid` is high whenever the level is nonzero.
- R3: A byte is removed when `tx_ready` and `tx_valid` are both high. A push and a removal in the same cycle leave the level unchanged.
- R4: A push made while the level equals the depth (32) is discarded. The stored bytes and the level are unchanged, and `ev_overflow` is high for exactly one cycle.
- R5: `status_word` bit 0 is 1 exactly when the level equals the depth, and it clears as soon as the level drops below it.
- R6: `status_word` bit 2 is 1 exactly when the level is 0. `ev_empty` pulses for one cycle whenever the level goes from nonzero to zero, whether by removal or by flush.
- R7: A bus write to offset 0x1C with bit 1 set makes the level 0. Bits 6:5 of the same write load the threshold code, which selects a threshold of 1, 4, 8 or 16 for codes 0, 1, 2 and 3.
- R8: `ev_watermark` is high while the level is at or above the threshold and low while the level is below it. It is therefore always low at level 0.
- R9: `level_word` bits 5:0 carry the fill level, bits 20:16 carry `rx_level`, and all other bits are 0. `status_word` bits 5:3 carry `rx_flags`.
- R10: Bus writes to any other offset change neither the level nor the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 6 | Bus write byte offset |
| bus_wdata | input | 8 | Bus write data |
| tx_ready | input | 1 | Transmitter takes the head byte |
| tx_valid | output | 1 | Head byte is present |
| tx_byte | output | 8 | Head byte |
| rx_flags | input | 3 | Receive-side flags placed in status bits 5:3 |
| rx_level | input | 5 | Receive-side level placed in level bits 20:16 |
| status_word | output | 32 | Full (bit 0), empty (bit 2), receive flags (bits 5:3) |
| level_word | output | 32 | Transmit level (bits 5:0), receive level (bits 20:16) |
| ev_watermark | output | 1 | Level at or above threshold |
| ev_empty | output | 1 | One-cycle pulse on draining to zero |
| ev_overflow | output | 1 | One-cycle pulse on a dropped push |

## Verification
Every result of a write or removal is due on the first clock edge after the stimulus cycle. The level, the flags, the watermark and the head byte come straight from registered state. The two event pulses are registered on that same edge and are gone one edge later. The bench drives inputs on the falling edge and samples at the following falling edge, so each check falls in the one cycle where the new value is due. Pulse checks also sample one more falling edge later to confirm the pulse has ended.

// File: rtl/tx_fifo_wm.sv
module tx_fifo_wm #(
  parameter int DEPTH    = 32,
  parameter int AW       = 6,
  parameter logic [5:0] DATA_OFS = 6'h18,
  parameter logic [5:0] CTRL_OFS = 6'h1C,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic          tx_ready,
  output logic          tx_valid,
  output logic [7:0]    tx_byte,
  input  logic [2:0]    rx_flags,
  input  logic [4:0]    rx_level,
  output logic [31:0]   status_word,
  output logic [31:0]   level_word,
  output logic          ev_watermark,
  output logic          ev_empty,
  output logic          ev_overflow
);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [LW-1:0] lvl, lvl_nxt, thr;
  logic [1:0]    thr_code;

  wire data_wr  = bus_we && (bus_addr == AW'(DATA_OFS));
  wire ctrl_wr  = bus_we && (bus_addr == AW'(CTRL_OFS));
  wire flush    = ctrl_wr && bus_wdata[1];
  wire is_full  = (lvl == LW'(DEPTH));
  wire is_empty = (lvl == '0);
  wire push     = data_wr && !is_full;
  wire pop      = tx_ready && !is_empty;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    lvl_nxt = lvl;
    if (flush)
      lvl_nxt = '0;
    else if (push && !pop)
      lvl_nxt = lvl + 1'b1;
    else if (pop && !push)
      lvl_nxt = lvl - 1'b1;
  end

  always_comb begin
    case (thr_code)
      2'd0:    thr = LW'(1);
      2'd1:    thr = LW'(4);
      2'd2:    thr = LW'(8);
      default: thr = LW'(16);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp          <= '0;
      rp          <= '0;
      lvl         <= '0;
      thr_code    <= '0;
      ev_empty    <= 1'b0;
      ev_overflow <= 1'b0;
    end else begin
      lvl         <= lvl_nxt;
      ev_empty    <= !is_empty && (lvl_nxt == '0);
      ev_overflow <= data_wr && is_full;
      if (ctrl_wr) thr_code <= bus_wdata[6:5];
      if (flush) begin
        wp <= '0;
        rp <= '0;
      end else begin
        if (push) wp <= bump(wp);
        if (pop)  rp <= bump(rp);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= bus_wdata;
  end

  assign tx_valid     = !is_empty;
  assign tx_byte      = mem[rp];
  assign ev_watermark = (lvl >= thr);
  assign status_word  = {26'd0, rx_flags, is_empty, 1'b0, is_full};

  always_comb begin
    level_word         = '0;
    level_word[LW-1:0] = lvl;
    level_word[20:16]  = rx_level;
  end

endmodule

// File: rtl/tx_fifo_wm_chk.sv
module tx_fifo_wm_chk #(
  parameter int DEPTH = 32,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [5:0]  bus_addr,
  input logic [7:0]  bus_wdata,
  input logic        tx_ready,
  input logic        tx_valid,
  input logic [31:0] status_word,
  input logic [31:0] level_word,
  input logic        ev_watermark,
  input logic        ev_empty,
  input logic        ev_overflow
);
  wire [LW-1:0] lvl = level_word[LW-1:0];
  wire wr_data = bus_we && bus_addr == 6'h18;
  wire wr_ctrl = bus_we && bus_addr == 6'h1C;

  assert_drop_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && status_word[0] && !tx_ready) |=> (ev_overflow && $stable(level_word[LW-1:0])));

  assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= LW'(DEPTH));

  assert_pushpop_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && tx_valid && tx_ready && !status_word[0]) |=> $stable(level_word[LW-1:0]));

  assert_empty_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_empty |-> (status_word[2] && !ev_watermark && !tx_valid));

  assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[1]) |=> (lvl == '0));

  assert_no_wm_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[2] |-> !ev_watermark);

  assert_other_offset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr != 6'h18 && bus_addr != 6'h1C && !tx_ready) |=> $stable(level_word[LW-1:0]));
endmodule

bind tx_fifo_wm tx_fifo_wm_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .tx_ready(tx_ready), .tx_valid(tx_valid),
  .status_word(status_word), .level_word(level_word),
  .ev_watermark(ev_watermark), .ev_empty(ev_empty), .ev_overflow(ev_overflow)
);

// File: tb/tx_fifo_wm_tb.sv
`timescale 1ns/1ps
module tx_fifo_wm_tb;
  logic clk = 0, rst_n = 0;
  logic bus_we = 0, tx_ready = 0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [2:0] rx_flags = 3'b111;
  logic [4:0] rx_level = '0;
  logic tx_valid, ev_watermark, ev_empty, ev_overflow;
  logic [7:0] tx_byte;
  logic [31:0] status_word, level_word;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  tx_fifo_wm u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .rx_flags(rx_flags), .rx_level(rx_level),
    .status_word(status_word), .level_word(level_word),
    .ev_watermark(ev_watermark), .ev_empty(ev_empty), .ev_overflow(ev_overflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic pop1(output logic [7:0] b);
    @(negedge clk); tx_ready = 1; b = tx_byte;
    @(negedge clk); tx_ready = 0;
  endtask

  task automatic t_reset();
    chk("R1 status", status_word, 32'h3C);
    chk("R1 level", level_word, 32'h0);
    chk("R1 valid", {29'd0, tx_valid, ev_empty, ev_overflow}, 32'h0);
    chk("R1 wm", {31'd0, ev_watermark}, 0);
  endtask

  task automatic t_order();
    logic [7:0] b;
    wr(6'h18, 8'hA1); wr(6'h18, 8'hB2); wr(6'h18, 8'hC3);
    chk("R2 level", level_word[5:0], 3);
    chk("R6 not empty", {31'd0, status_word[2]}, 0);
    chk("R2 valid", {31'd0, tx_valid}, 1);
    pop1(b); chk("R2 order0", b, 8'hA1);
    pop1(b); chk("R2 order1", b, 8'hB2);
    pop1(b); chk("R2 order2", b, 8'hC3);
    chk("R6 empty pulse", {31'd0, ev_empty}, 1);
    chk("R6 empty bit", {31'd0, status_word[2]}, 1);
    @(negedge clk);
    chk("R6 pulse ends", {31'd0, ev_empty}, 0);
  endtask

  task automatic t_threshold();
    logic [7:0] b;
    int thr;
    for (int code = 0; code < 4; code++) begin
      thr = (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 16;
      wr(6'h1C, 8'((code << 5) | 2));
      for (int i = 0; i < thr - 1; i++) wr(6'h18, 8'(i));
      chk("R8 below", {31'd0, ev_watermark}, 0);
      wr(6'h18, 8'h55);
      chk("R7 R8 at threshold", {31'd0, ev_watermark}, 1);
      pop1(b);
      chk("R8 falls below", {31'd0, ev_watermark}, 0);
    end
    wr(6'h1C, 8'h02);
  endtask

  task automatic t_full();
    logic [7:0] b;
    wr(6'h1C, 8'h02);
    for (int i = 0; i < 31; i++) wr(6'h18, 8'(i * 3 + 1));
    chk("R5 not full at 31", {31'd0, status_word[0]}, 0);
    wr(6'h18, 8'(31 * 3 + 1));
    chk("R5 full at 32", {31'd0, status_word[0]}, 1);
    chk("R9 level 32", level_word, 32);
    wr(6'h18, 8'hEE);
    chk("R4 overflow pulse", {31'd0, ev_overflow}, 1);
    chk("R4 level kept", level_word[5:0], 32);
    @(negedge clk);
    chk("R4 pulse ends", {31'd0, ev_overflow}, 0);
    pop1(b);
    chk("R4 head kept", b, 8'h01);
    chk("R5 clears at 31", {31'd0, status_word[0]}, 0);
    for (int i = 1; i < 32; i++) begin
      pop1(b);
      chk("R4 contents", b, 8'(i * 3 + 1));
    end
    chk("R6 drained", {31'd0, status_word[2]}, 1);
  endtask

  task automatic t_pushpop();
    logic [7:0] b;
    wr(6'h18, 8'h10); wr(6'h18, 8'h20);
    @(negedge clk); bus_we = 1; bus_addr = 6'h18; bus_wdata = 8'h30; tx_ready = 1;
    @(negedge clk); bus_we = 0; tx_ready = 0;
    chk("R3 level held", level_word[5:0], 2);
    pop1(b); chk("R3 next byte", b, 8'h20);
    pop1(b); chk("R3 pushed byte", b, 8'h30);
  endtask

  task automatic t_flush_other();
    wr(6'h18, 8'h77); wr(6'h18, 8'h88);
    wr(6'h14, 8'h99); wr(6'h00, 8'hFF);
    chk("R10 other offsets", level_word[5:0], 2);
    wr(6'h1C, 8'h02);
    chk("R7 flush level", level_word[5:0], 0);
    chk("R6 flush pulse", {31'd0, ev_empty}, 1);
    chk("R7 no valid", {31'd0, tx_valid}, 0);
  endtask

  task automatic t_fields();
    rx_level = 5'h15; rx_flags = 3'b010;
    wr(6'h18, 8'h01);
    chk("R9 level word", level_word, 32'h0015_0001);
    chk("R9 status word", status_word, 32'h10);
    wr(6'h1C, 8'h02);
    rx_flags = 3'b111; rx_level = 0;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_order();
    t_threshold();
    t_full();
    t_pushpop();
    t_flush_other();
    t_fields();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule